// File: doc/BRIEF.md
# LED Matrix Row Scan Timing Generator

This block drives a chain of LED matrix panels that are built from serial shift registers with a latch and a shared output enable. For each row it fetches one bit plane of colour data through a pixel read port and shifts it out on six colour lines with a shift clock. The six lines carry an upper-half and a lower-half RGB triple. It then pulses the latch and lights the panel for a time weighted by the plane's binary significance. The next plane is shifted while the current one is lit.

All bit planes of a row are shown before the 4-bit row address moves on to the next of the 16 rows, because the row decoders settle slowly. The clock-high time, the clock-low hold time, the data setup time, the latch width and the lighting time unit each have their own input. The block takes these values only when the row address changes, so an edit mid-row never distorts a pulse. A wait value of zero is treated as one cycle.

Top module: `led_matrix_scan`

## Requirements
- R1: While reset is applied and right after it, oe_n is 1, lat is 0, sclk is 0, rgb is 0 and row_addr is 0.
- R2: Each shift gives exactly COLS sclk rising edges. At the rising edge for column c, with c counting from 0, rgb equals pix_data read at that column for the row and plane being shifted. rgb[5:3] is the upper half (red, green, blue) and rgb[2:0] is the lower half (red, green, blue).
- R3: sclk stays high for max(cfg_clk_hi,1) cycles.
- R4: rgb changes only while sclk is low, exactly max(cfg_setup,1) cycles before a rising edge. Within a shift, sclk is low for max(cfg_clk_lo,1)+max(cfg_setup,1) cycles between pulses.
- R5: A colour line whose next value equals its current value does not move. Between two rising edges, rgb changes at most once, and only if the two column values differ.
- R6: lat is high for max(cfg_lat,1) cycles, with sclk low. It rises only after all COLS pulses of the shift.
- R7: oe_n is 1 whenever lat is 1. row_addr changes only in a cycle where oe_n is 1 and was 1 in the cycle before.
- R8: After plane k is latched, oe_n goes low for exactly max(cfg_on_unit,1)·2^k cycles.
- R9: Shifts run plane 0 to PLANES-1 of a row, then plane 0 of the next row. row_addr steps by one modulo 16, from 15 back to 0, and changes exactly when plane 0 of the new row is latched.
- R10: The next plane is shifted while the current plane is lit. lat rises only once the lit time of the previous plane has fully ended.
- R11: The five wait inputs are taken at reset release and when row_addr changes. Changes at other times take no effect until the next row change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_hi | input | CNT_W | Shift clock high time in cycles |
| cfg_clk_lo | input | CNT_W | Cycles from falling edge to next data change |
| cfg_setup | input | CNT_W | Cycles from data change to rising edge |
| cfg_lat | input | CNT_W | Latch pulse width in cycles |
| cfg_on_unit | input | CNT_W | Lit time of plane 0 in cycles |
| pix_row | output | 4 | Row being fetched |
| pix_col | output | clog2(COLS) | Column being fetched |
| pix_plane | output | clog2(PLANES) | Bit plane being fetched |
| pix_data | input | 6 | Colour bits at the fetch address, same cycle |
| rgb | output | 6 | Colour lines, upper RGB in [5:3], lower in [2:0] |
| sclk | output | 1 | Shift clock |
| lat | output | 1 | Latch strobe |
| oe_n | output | 1 | Output enable, low lights the panel |
| row_addr | output | 4 | Row address lines |

## Verification
The scan is run with six sets of wait values. Each set is applied in the middle of a row, so the measured widths show whether values are taken only at row changes. The pixel pattern repeats every second column and varies by row and plane. This separates correct column and plane ordering, static lines during runs of equal bits, and stray toggles. One set uses a long lit time, so the latch has to wait for the display and not for the shift. Another uses all zeros, which checks the clamp to one cycle. Row wrap-around and a reset taken mid-scan are exercised in the same run.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {SH_IDLE, SH_SETUP, SH_HIGH, SH_HOLD} sh_state_t;
  typedef enum logic [2:0] {SQ_INIT, SQ_KICK, SQ_WAIT, SQ_LATCH, SQ_SWITCH} sq_state_t;
endpackage

// File: rtl/scan_shifter.sv
module scan_shifter
  import scan_pkg::*;
#(
  parameter int COLS  = 192,
  parameter int CNT_W = 8,
  parameter int DW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] wt_hi,
  input  logic [CNT_W-1:0] wt_lo,
  input  logic [CNT_W-1:0] wt_setup,
  input  logic [DW-1:0]    pix_data,
  output logic [$clog2(COLS)-1:0] pix_col,
  output logic             busy,
  output logic             sclk,
  output logic [DW-1:0]    rgb
);
  localparam int COL_W = $clog2(COLS);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  sh_state_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             fin_q, fin_d;
  logic             load;
  logic [DW-1:0]    rgb_q;

  function automatic logic [CNT_W-1:0] minus1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    col_d = col_q;
    fin_d = fin_q;
    load  = 1'b0;
    unique case (st_q)
      SH_IDLE: if (start) begin
        load  = 1'b1;
        st_d  = SH_SETUP;
        cnt_d = minus1(wt_setup);
      end
      SH_SETUP: if (cnt_q == '0) begin
        st_d  = SH_HIGH;
        cnt_d = minus1(wt_hi);
      end else cnt_d = cnt_q - 1'b1;
      SH_HIGH: if (cnt_q == '0) begin
        st_d  = SH_HOLD;
        cnt_d = minus1(wt_lo);
        if (col_q == LAST_COL) begin
          fin_d = 1'b1;
          col_d = '0;
        end else col_d = col_q + 1'b1;
      end else cnt_d = cnt_q - 1'b1;
      SH_HOLD: if (cnt_q == '0) begin
        if (fin_q) begin
          st_d  = SH_IDLE;
          fin_d = 1'b0;
        end else begin
          load  = 1'b1;
          st_d  = SH_SETUP;
          cnt_d = minus1(wt_setup);
        end
      end else cnt_d = cnt_q - 1'b1;
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      cnt_q <= '0;
      col_q <= '0;
      fin_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      col_q <= col_d;
      fin_q <= fin_d;
    end
  end

  // each colour line only gets a write enable when its value really moves
  for (genvar i = 0; i < DW; i++) begin : g_line
    logic wr_en;
    assign wr_en = load && (rgb_q[i] != pix_data[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rgb_q[i] <= 1'b0;
      else if (wr_en) rgb_q[i] <= pix_data[i];
    end
  end

  assign pix_col = col_q;
  assign busy    = (st_q != SH_IDLE);
  assign sclk    = (st_q == SH_HIGH);
  assign rgb     = rgb_q;

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(rgb_q)); // R4
  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rgb_q) |-> !sclk); // R4
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int PLANES   = 4,
  parameter int ROW_BITS = 4,
  parameter int CNT_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          cfg_clk_hi,
  input  logic [CNT_W-1:0]          cfg_clk_lo,
  input  logic [CNT_W-1:0]          cfg_setup,
  input  logic [CNT_W-1:0]          cfg_lat,
  input  logic [CNT_W-1:0]          cfg_on_unit,
  input  logic                      shift_busy,
  output logic [CNT_W-1:0]          wt_hi,
  output logic [CNT_W-1:0]          wt_lo,
  output logic [CNT_W-1:0]          wt_setup,
  output logic                      shift_start,
  output logic [ROW_BITS-1:0]       fetch_row,
  output logic [$clog2(PLANES)-1:0] fetch_plane,
  output logic [ROW_BITS-1:0]       row_addr,
  output logic                      lat,
  output logic                      oe_n
);
  localparam int PLANE_W = $clog2(PLANES);
  localparam int ON_W    = CNT_W + PLANES;
  localparam logic [PLANE_W-1:0] LAST_PLANE = PLANE_W'(PLANES - 1);

  sq_state_t           st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [ON_W-1:0]     on_q, on_d;
  logic                oe_n_q, oe_n_d, lat_q, lat_d, cap;
  logic [ROW_BITS-1:0] row_q, row_d, s_row_q, s_row_d;
  logic [PLANE_W-1:0]  s_pl_q, s_pl_d, d_pl_q, d_pl_d;
  logic [CNT_W-1:0]    hi_q, lo_q, su_q, lw_q, un_q;

  function automatic logic [CNT_W-1:0] floor1(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  on_d = on_q;  oe_n_d = oe_n_q;  lat_d = lat_q;
    row_d = row_q;  s_row_d = s_row_q;  s_pl_d = s_pl_q;  d_pl_d = d_pl_q;
    cap = 1'b0;  shift_start = 1'b0;
    // lit-time countdown runs beside the shift
    if (!oe_n_q) begin
      if (on_q <= ON_W'(1)) begin
        oe_n_d = 1'b1;
        on_d   = '0;
      end else on_d = on_q - 1'b1;
    end
    unique case (st_q)
      SQ_INIT: begin
        cap  = 1'b1;
        st_d = SQ_KICK;
      end
      SQ_KICK: begin
        shift_start = 1'b1;
        st_d        = SQ_WAIT;
      end
      SQ_WAIT: if (!shift_busy && oe_n_q) begin
        st_d  = SQ_LATCH;
        lat_d = 1'b1;
        cnt_d = floor1(lw_q) - 1'b1;
      end
      SQ_LATCH: if (cnt_q == '0) begin
        lat_d  = 1'b0;
        st_d   = SQ_SWITCH;
        d_pl_d = s_pl_q;
        if (s_pl_q == '0) begin
          row_d = s_row_q;
          cap   = 1'b1;
        end
        if (s_pl_q == LAST_PLANE) begin
          s_pl_d  = '0;
          s_row_d = s_row_q + 1'b1;
        end else s_pl_d = s_pl_q + 1'b1;
      end else cnt_d = cnt_q - 1'b1;
      SQ_SWITCH: begin
        oe_n_d = 1'b0;
        on_d   = ON_W'(floor1(un_q)) << d_pl_q;
        st_d   = SQ_KICK;
      end
      default: st_d = SQ_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_INIT;  cnt_q <= '0;  on_q <= '0;  oe_n_q <= 1'b1;  lat_q <= 1'b0;
      row_q <= '0;  s_row_q <= '0;  s_pl_q <= '0;  d_pl_q <= '0;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  on_q <= on_d;  oe_n_q <= oe_n_d;  lat_q <= lat_d;
      row_q <= row_d;  s_row_q <= s_row_d;  s_pl_q <= s_pl_d;  d_pl_q <= d_pl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;  lo_q <= '0;  su_q <= '0;  lw_q <= '0;  un_q <= '0;
    end else if (cap) begin
      hi_q <= cfg_clk_hi;  lo_q <= cfg_clk_lo;  su_q <= cfg_setup;
      lw_q <= cfg_lat;     un_q <= cfg_on_unit;
    end
  end

  assign wt_hi       = floor1(hi_q);
  assign wt_lo       = floor1(lo_q);
  assign wt_setup    = floor1(su_q);
  assign fetch_row   = s_row_q;
  assign fetch_plane = s_pl_q;
  assign row_addr    = row_q;
  assign lat         = lat_q;
  assign oe_n        = oe_n_q;

  AST_LAT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q |-> oe_n_q); // R7
  AST_ADDR_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (row_q != $past(row_q)) |-> (oe_n_q && $past(oe_n_q))); // R7
  AST_LAT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> !shift_busy); // R10
  AST_PLANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_pl_q <= LAST_PLANE) && (d_pl_q <= LAST_PLANE)); // R9
endmodule

// File: rtl/led_matrix_scan.sv
module led_matrix_scan
  import scan_pkg::*;
#(
  parameter int COLS   = 192,
  parameter int PLANES = 4,
  parameter int CNT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          cfg_clk_hi,
  input  logic [CNT_W-1:0]          cfg_clk_lo,
  input  logic [CNT_W-1:0]          cfg_setup,
  input  logic [CNT_W-1:0]          cfg_lat,
  input  logic [CNT_W-1:0]          cfg_on_unit,
  output logic [3:0]                pix_row,
  output logic [$clog2(COLS)-1:0]   pix_col,
  output logic [$clog2(PLANES)-1:0] pix_plane,
  input  logic [5:0]                pix_data,
  output logic [5:0]                rgb,
  output logic                      sclk,
  output logic                      lat,
  output logic                      oe_n,
  output logic [3:0]                row_addr
);
  localparam int ROW_BITS = 4;

  logic             rst_meta_q, rst_int_n;
  logic             shift_busy, shift_start;
  logic [CNT_W-1:0] wt_hi, wt_lo, wt_setup;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  scan_sequencer #(.PLANES(PLANES), .ROW_BITS(ROW_BITS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_clk_hi(cfg_clk_hi), .cfg_clk_lo(cfg_clk_lo), .cfg_setup(cfg_setup),
    .cfg_lat(cfg_lat), .cfg_on_unit(cfg_on_unit),
    .shift_busy(shift_busy),
    .wt_hi(wt_hi), .wt_lo(wt_lo), .wt_setup(wt_setup),
    .shift_start(shift_start),
    .fetch_row(pix_row), .fetch_plane(pix_plane),
    .row_addr(row_addr), .lat(lat), .oe_n(oe_n)
  );

  scan_shifter #(.COLS(COLS), .CNT_W(CNT_W), .DW(6)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .start(shift_start),
    .wt_hi(wt_hi), .wt_lo(wt_lo), .wt_setup(wt_setup),
    .pix_data(pix_data), .pix_col(pix_col),
    .busy(shift_busy), .sclk(sclk), .rgb(rgb)
  );

  AST_LAT_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    lat |-> !sclk); // R6
endmodule

// File: tb/led_matrix_scan_bench.sv
module led_matrix_scan_bench;
  localparam int COLS = 8, PLANES = 3, CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] c_hi, c_lo, c_su, c_lat, c_un;
  logic [3:0] pix_row, row_addr;
  logic [$clog2(COLS)-1:0] pix_col;
  logic [$clog2(PLANES)-1:0] pix_plane;
  logic [5:0] pix_data, rgb;
  logic sclk, lat, oe_n;

  always #2.5 clk = ~clk;

  function automatic logic [5:0] pixf(input int row, input int col, input int plane);
    return 6'((((col >> 1) * 13) ^ (row * 7) ^ (plane * 21)) & 63);
  endfunction
  function automatic int e1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  assign pix_data = pixf(int'(pix_row), int'(pix_col), int'(pix_plane));

  led_matrix_scan #(.COLS(COLS), .PLANES(PLANES), .CNT_W(CNT_W)) u_led_matrix_scan (
    .clk(clk), .rst_n(rst_n),
    .cfg_clk_hi(c_hi), .cfg_clk_lo(c_lo), .cfg_setup(c_su), .cfg_lat(c_lat), .cfg_on_unit(c_un),
    .pix_row(pix_row), .pix_col(pix_col), .pix_plane(pix_plane), .pix_data(pix_data),
    .rgb(rgb), .sclk(sclk), .lat(lat), .oe_n(oe_n), .row_addr(row_addr)
  );

  // {hi, lo, setup, lat, on_unit}
  localparam logic [39:0] VEC [6] = '{
    {8'd1, 8'd1, 8'd1, 8'd1, 8'd1},
    {8'd2, 8'd3, 8'd1, 8'd4, 8'd2},
    {8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd3, 8'd1, 8'd4, 8'd2, 8'd40},
    {8'd1, 8'd2, 8'd3, 8'd6, 8'd1},
    {8'd5, 8'd1, 8'd2, 8'd1, 8'd3}
  };

  int n_chk = 0, n_fail = 0;
  bit mon_en = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic apply(input logic [39:0] v);
    {c_hi, c_lo, c_su, c_lat, c_un} = v;
  endtask

  // monitor state
  int x_hi, x_lo, x_su, x_lat, x_un;
  int hi_run, lo_run, lat_run, oe_run, since, nchg;
  int col_idx, lat_cnt, oe_done, chg_cnt, wraps, ovl;
  int exp_px, p_exp, exp_on;
  logic p_sclk, p_lat, p_oe;
  logic [5:0] p_rgb;
  logic [3:0] p_row;

  always @(negedge clk) begin
    if (!rst_n || !mon_en) begin
      x_hi = int'(c_hi); x_lo = int'(c_lo); x_su = int'(c_su); x_lat = int'(c_lat); x_un = int'(c_un);
      hi_run = 0; lo_run = 0; lat_run = 0; oe_run = 0; since = 0; nchg = 0;
      col_idx = 0; lat_cnt = 0; oe_done = 0; p_exp = 0;
      p_sclk = 1'b0; p_lat = 1'b0; p_oe = 1'b1; p_rgb = '0; p_row = '0;
    end else begin
      // shift clock edges
      if (sclk && !p_sclk) begin
        exp_px = int'(pixf((lat_cnt / PLANES) % 16, col_idx, lat_cnt % PLANES));
        check(int'(rgb) == exp_px, "R2 colour bits at rising edge", int'(rgb), exp_px);
        check(col_idx < COLS, "R2 pulse count within a shift", col_idx, COLS - 1);
        if (col_idx > 0)
          check(lo_run == e1(x_lo) + e1(x_su), "R4 clock low width", lo_run, e1(x_lo) + e1(x_su));
        if (nchg > 0)
          check(since == e1(x_su), "R4 data setup before rising edge", since, e1(x_su));
        check(nchg == ((exp_px != p_exp) ? 1 : 0), "R5 changes between edges", nchg,
              (exp_px != p_exp) ? 1 : 0);
        if (!oe_n) ovl++;
        p_exp = exp_px; col_idx++; nchg = 0; hi_run = 1;
      end else if (!sclk && p_sclk) begin
        check(hi_run == e1(x_hi), "R3 clock high width", hi_run, e1(x_hi));
        lo_run = 1;
      end else if (sclk) hi_run++;
      else lo_run++;
      // latch
      if (lat && !p_lat) begin
        check(col_idx == COLS, "R6 latch after full shift", col_idx, COLS);
        check(!sclk, "R6 latch with clock low", int'(sclk), 0);
        check(oe_n, "R7 dark during latch", int'(oe_n), 1);
        check(oe_done == lat_cnt, "R10 latch waits for lit time", oe_done, lat_cnt);
        lat_cnt++; col_idx = 0; lat_run = 1;
      end else if (!lat && p_lat) begin
        check(lat_run == e1(x_lat), "R6 latch width", lat_run, e1(x_lat));
      end else if (lat) lat_run++;
      // output enable
      if (!oe_n && p_oe) begin
        oe_run = 1;
      end else if (oe_n && !p_oe) begin
        exp_on = e1(x_un) << (oe_done % PLANES);
        check(oe_run == exp_on, "R8 lit time for plane", oe_run, exp_on);
        oe_done++;
      end else if (!oe_n) oe_run++;
      // row address
      if (row_addr != p_row) begin
        check(oe_n && p_oe, "R7 address moves only while dark", int'(oe_n), 1);
        check(int'(row_addr) == (int'(p_row) + 1) % 16, "R9 row step", int'(row_addr),
              (int'(p_row) + 1) % 16);
        check(((lat_cnt - 1) % PLANES == 0) && (((lat_cnt - 1) / PLANES) % 16 == int'(row_addr)),
              "R9 row change on plane 0 latch", lat_cnt - 1, int'(row_addr) * PLANES);
        if (row_addr == 4'd0) wraps++;
        // R11: new wait values only from here on
        x_hi = int'(c_hi); x_lo = int'(c_lo); x_su = int'(c_su); x_lat = int'(c_lat); x_un = int'(c_un);
        chg_cnt++;
      end
      // colour line activity
      if (rgb != p_rgb) begin since = 1; nchg++; end
      else since++;
      p_sclk = sclk; p_lat = lat; p_oe = oe_n; p_rgb = rgb; p_row = row_addr;
    end
  end

  initial begin
    chg_cnt = 0; wraps = 0; ovl = 0;
    apply(VEC[0]);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(oe_n && !lat && !sclk && rgb == '0 && row_addr == '0, "R1 outputs in reset",
          int'({oe_n, lat, sclk}), 4);
    @(posedge clk); #1 rst_n = 1'b1; mon_en = 1'b1;
    @(negedge clk);
    check(oe_n && !lat && !sclk && row_addr == '0, "R1 outputs after release",
          int'({oe_n, lat, sclk}), 4);
    for (int v = 0; v < 6; v++) begin
      int base;
      base = chg_cnt;
      while (chg_cnt <= base) @(posedge clk);
      repeat (7) @(posedge clk);
      #1 apply(VEC[v]);          // R11: lands mid-row
      base = chg_cnt;
      while (chg_cnt < base + 2) @(posedge clk);
    end
    check(wraps >= 1, "R9 row address wraps to 0", wraps, 1);
    check(ovl > 0, "R10 shift overlaps lit time", ovl, 1);
    check(oe_done > 0 && lat_cnt > 0, "R8 planes displayed", oe_done, lat_cnt);
    @(posedge clk); #1 mon_en = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check(oe_n && !lat && !sclk && rgb == '0 && row_addr == '0, "R1 reset mid-scan",
          int'({oe_n, lat, sclk}), 4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule